// File: doc/BRIEF.md
# Multi-Mode Counter Timer Channel

This block is one 16-bit counter channel. A 3-bit mode field chooses how it counts. It watches two external count inputs, a primary and a secondary, which arrive already selected and may be asynchronous to the clock. Each input passes through a two-flop synchroniser and an edge detector. A mode decoder turns the synchronised levels and edges into up-steps and down-steps, at most one step per clock.

A small state machine owns the counter. The states are ST_RUN1 (counting towards compare value 1), ST_RUN2 (counting towards compare value 2), ST_WAIT (trigger mode, armed and waiting) and ST_HALT (one-shot finished). The transitions are named as follows:

- WRITE: a mode strobe from any state leads to ST_WAIT in trigger mode, or to ST_RUN1 otherwise.
- ARM_FIRE: in ST_WAIT, a secondary rising edge leads to ST_RUN1.
- WRAP: a repeating match reloads the counter. It stays in ST_RUN1, or goes back to ST_WAIT in trigger mode.
- STAGE: a one-shot match on value 1 with two-stage compare enabled leads from ST_RUN1 to ST_RUN2.
- FINISH: a one-shot final match leads to ST_HALT.

A step whose next value equals the active compare value is a match. A match raises a one-cycle compare flag. Software-side logic configures the channel by presenting the mode, the option bits and the load and compare values, then pulsing the mode strobe. The strobe also reloads the counter from the load value.

Top module: `ctmr_channel`

## Requirements
- R1: After reset, cnt_o is 0, cmp_flag_o is 0 and the channel is in ST_RUN1.
- R2: One clock after mode_wr_i is high at an edge, cnt_o equals the load_i sampled at that edge and cmp_flag_o is 0. The state becomes ST_WAIT when mode_i is 3'b110 and ST_RUN1 otherwise, and any halt is cleared.
- R3: A level change on pri_in_i or sec_in_i takes effect at the third rising clock edge after it. In mode 3'b001, pri_pol_i = 0 counts primary rising edges and pri_pol_i = 1 counts falling edges, each one up.
- R4: With pri_is_clk_i = 1, modes 3'b001, 3'b101 and 3'b110 count every clock regardless of pri_pol_i, and mode 3'b011 counts every clock while the secondary is high. Mode 3'b010 counts nothing.
- R5: Mode 3'b010 counts up on both edges of the primary input.
- R6: Mode 3'b011 counts primary rising edges only while the synchronised secondary level is 1.
- R7: Mode 3'b100 is 4x quadrature with primary as phase A and secondary as phase B. The sequence AB = 00,10,11,01 counts up, the reverse counts down, and a change of both phases in one cycle is ignored.
- R8: Mode 3'b101 counts the polarity-selected primary edge up when the secondary level is 0 and down when it is 1.
- R9: In mode 3'b110 the counter holds in ST_WAIT. A secondary rising edge moves it to ST_RUN1, where it counts primary rising edges. A repeating match returns it to ST_WAIT.
- R10: Mode 3'b111 counts up on a casc_up_i pulse and down on a casc_dn_i pulse. Both pulses together produce no step.
- R11: When a step's next value equals the active compare value, the counter is loaded with load_i instead and cmp_flag_o is 1 for that cycle. With one_shot_i = 0 counting continues.
- R12: With one_shot_i = 1 and dual_cmp_i = 0, a match leaves cnt_o at the compare value and enters ST_HALT. The counter then holds until the next mode write.
- R13: With one_shot_i = 1 and dual_cmp_i = 1, a match on cmp1_i reloads from load_i and enters ST_RUN2. A later match on cmp2_i holds that value and halts.
- R14: Mode 3'b000, or pri_is_self_i = 1, produces no count in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Count mode select |
| mode_wr_i | input | 1 | One-cycle mode write strobe; reloads and restarts |
| one_shot_i | input | 1 | 1 = stop after final compare |
| dual_cmp_i | input | 1 | 1 = two-stage compare in one-shot |
| pri_in_i | input | 1 | Primary count input (asynchronous) |
| sec_in_i | input | 1 | Secondary count input (asynchronous) |
| pri_pol_i | input | 1 | Primary edge polarity, 1 = falling |
| pri_is_clk_i | input | 1 | Primary source is the system clock |
| pri_is_self_i | input | 1 | Primary source is this channel's own output |
| casc_up_i | input | 1 | Neighbour counter up pulse (synchronous) |
| casc_dn_i | input | 1 | Neighbour counter down pulse (synchronous) |
| load_i | input | 16 | Reload value |
| cmp1_i | input | 16 | First compare value |
| cmp2_i | input | 16 | Second compare value |
| cnt_o | output | 16 | Counter value |
| cmp_flag_o | output | 1 | One-cycle compare match flag |

## Verification
The assertions assume three things about the inputs. Configuration inputs, the source flags and the cascade pulses are synchronous to the clock. The mode strobe is a single-cycle pulse. The load value seen at a match is the value the counter is meant to take. The stimulus changes every input only on the falling clock edge. It applies configuration changes together with a mode strobe, and it holds each primary or secondary level for three clocks, so that every edge passes the synchroniser. The quadrature stimulus walks legal Gray steps in both directions and then forces a deliberate double-phase change.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [2:0] {
        CM_IDLE   = 3'b000,
        CM_RISE   = 3'b001,
        CM_BOTH   = 3'b010,
        CM_GATED  = 3'b011,
        CM_QUAD   = 3'b100,
        CM_DIRPIN = 3'b101,
        CM_TRIG   = 3'b110,
        CM_CASC   = 3'b111
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_RUN1 = 2'd0,
        ST_RUN2 = 2'd1,
        ST_WAIT = 2'd2,
        ST_HALT = 2'd3
    } chan_state_e;

endpackage

// File: rtl/ctmr_edge_sync.sv
module ctmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    // STAGES must be 2 or more
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/ctmr_mode_dec.sv
module ctmr_mode_dec
    import ctmr_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       pri_lvl_i,
    input  logic       pri_rise_i,
    input  logic       pri_fall_i,
    input  logic       sec_lvl_i,
    input  logic       sec_rise_i,
    input  logic       sec_fall_i,
    input  logic       pri_pol_i,
    input  logic       pri_is_clk_i,
    input  logic       pri_is_self_i,
    input  logic       casc_up_i,
    input  logic       casc_dn_i,
    output logic       step_up_o,
    output logic       step_dn_o,
    output logic       trig_o
);
    cnt_mode_e mode;
    logic      pol_edge;
    logic      rise_or_clk;
    logic      pri_chg;
    logic      sec_chg;
    logic      sec_prev;
    logic      quad_one;
    logic      up_raw;
    logic      dn_raw;

    assign mode        = cnt_mode_e'(mode_i);
    assign pol_edge    = pri_is_clk_i ? 1'b1 : (pri_pol_i ? pri_fall_i : pri_rise_i);
    assign rise_or_clk = pri_is_clk_i | pri_rise_i;
    assign pri_chg     = pri_rise_i | pri_fall_i;
    assign sec_chg     = sec_rise_i | sec_fall_i;
    assign sec_prev    = sec_lvl_i ^ sec_chg;
    assign quad_one    = pri_chg ^ sec_chg;

    always_comb begin
        up_raw = 1'b0;
        dn_raw = 1'b0;
        unique case (mode)
            CM_IDLE:   ;
            CM_RISE:   up_raw = pol_edge;
            CM_BOTH:   up_raw = ~pri_is_clk_i & pri_chg;
            CM_GATED:  up_raw = rise_or_clk & sec_lvl_i;
            CM_QUAD: begin
                up_raw = quad_one & (pri_lvl_i ^ sec_prev);
                dn_raw = quad_one & ~(pri_lvl_i ^ sec_prev);
            end
            CM_DIRPIN: begin
                up_raw = pol_edge & ~sec_lvl_i;
                dn_raw = pol_edge & sec_lvl_i;
            end
            CM_TRIG:   up_raw = rise_or_clk;
            CM_CASC: begin
                up_raw = casc_up_i & ~casc_dn_i;
                dn_raw = casc_dn_i & ~casc_up_i;
            end
        endcase
    end

    assign step_up_o = up_raw & ~pri_is_self_i;
    assign step_dn_o = dn_raw & ~pri_is_self_i;
    assign trig_o    = sec_rise_i;

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             mode_wr_i,
    input  logic             one_shot_i,
    input  logic             dual_cmp_i,
    input  logic             step_up_i,
    input  logic             step_dn_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output chan_state_e      state_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cmp_act;
    logic             stepping;
    logic             is_trig;

    assign is_trig  = (cnt_mode_e'(mode_i) == CM_TRIG);
    assign stepping = step_up_i ^ step_dn_i;
    assign nxt      = step_up_i ? (cnt_q + CNT_ONE) : (cnt_q - CNT_ONE);
    assign cmp_act  = (state_q == ST_RUN2) ? cmp2_i : cmp1_i;

    // next state and next datapath values
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        flag_d  = 1'b0;
        if (mode_wr_i) begin
            cnt_d   = load_i;
            state_d = is_trig ? ST_WAIT : ST_RUN1;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (trig_i) state_d = ST_RUN1;
                end
                ST_RUN1, ST_RUN2: begin
                    if (stepping) begin
                        if (nxt == cmp_act) begin
                            flag_d = 1'b1;
                            if (one_shot_i) begin
                                if (state_q == ST_RUN1 && dual_cmp_i) begin
                                    cnt_d   = load_i;
                                    state_d = ST_RUN2;
                                end else begin
                                    cnt_d   = nxt;
                                    state_d = ST_HALT;
                                end
                            end else begin
                                cnt_d   = load_i;
                                state_d = is_trig ? ST_WAIT : ST_RUN1;
                            end
                        end else begin
                            cnt_d = nxt;
                        end
                    end
                end
                ST_HALT: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN1;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign flag_o  = flag_q;
    assign state_o = state_q;

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             mode_wr_i,
    input  logic             one_shot_i,
    input  logic             dual_cmp_i,
    input  logic             pri_in_i,
    input  logic             sec_in_i,
    input  logic             pri_pol_i,
    input  logic             pri_is_clk_i,
    input  logic             pri_is_self_i,
    input  logic             casc_up_i,
    input  logic             casc_dn_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cmp_flag_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] pins;
    logic [N_IN-1:0] lvl, rise, fall;
    logic            step_up, step_dn, trig;
    chan_state_e     core_state;

    assign pins = {sec_in_i, pri_in_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        ctmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    ctmr_mode_dec u_dec (
        .mode_i        (mode_i),
        .pri_lvl_i     (lvl[0]),
        .pri_rise_i    (rise[0]),
        .pri_fall_i    (fall[0]),
        .sec_lvl_i     (lvl[1]),
        .sec_rise_i    (rise[1]),
        .sec_fall_i    (fall[1]),
        .pri_pol_i     (pri_pol_i),
        .pri_is_clk_i  (pri_is_clk_i),
        .pri_is_self_i (pri_is_self_i),
        .casc_up_i     (casc_up_i),
        .casc_dn_i     (casc_dn_i),
        .step_up_o     (step_up),
        .step_dn_o     (step_dn),
        .trig_o        (trig)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .mode_wr_i  (mode_wr_i),
        .one_shot_i (one_shot_i),
        .dual_cmp_i (dual_cmp_i),
        .step_up_i  (step_up),
        .step_dn_i  (step_dn),
        .trig_i     (trig),
        .load_i     (load_i),
        .cmp1_i     (cmp1_i),
        .cmp2_i     (cmp2_i),
        .cnt_o      (cnt_o),
        .flag_o     (cmp_flag_o),
        .state_o    (core_state)
    );

endmodule

// File: rtl/ctmr_channel_chk.sv
module ctmr_channel_chk
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             mode_wr_i,
    input logic             pri_is_self_i,
    input logic [CNT_W-1:0] load_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             cmp_flag_o,
    input chan_state_e      state
);

    assert_mode_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> (cnt_o == $past(load_i)) && !cmp_flag_o);

    assert_idle_mode_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000 && !mode_wr_i) |=> $stable(cnt_o));

    assert_self_source_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_is_self_i && !mode_wr_i) |=> $stable(cnt_o));

    assert_halt_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !mode_wr_i) |=> $stable(cnt_o) && !cmp_flag_o && state == ST_HALT);

    assert_match_reloads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag_o && state != ST_HALT) |-> cnt_o == $past(load_i));

    assert_wait_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !mode_wr_i) |=> $stable(cnt_o));

endmodule

bind ctmr_channel ctmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .mode_wr_i     (mode_wr_i),
    .pri_is_self_i (pri_is_self_i),
    .load_i        (load_i),
    .cnt_o         (cnt_o),
    .cmp_flag_o    (cmp_flag_o),
    .state         (core_state)
);

// File: tb/ctmr_channel_tb.sv
`timescale 1ns/1ps
module ctmr_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        wr = 1'b0, os = 1'b0, dual = 1'b0;
    logic        pri = 1'b0, sec = 1'b0, pol = 1'b0, pclk = 1'b0, pself = 1'b0;
    logic        cu = 1'b0, cd = 1'b0;
    logic [15:0] load = 16'd0, c1 = 16'd100, c2 = 16'd200;
    logic [15:0] cnt;
    logic        flag;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    live = 1'b0;

    always #2 clk = ~clk;

    ctmr_channel u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .mode_wr_i(wr),
        .one_shot_i(os), .dual_cmp_i(dual), .pri_in_i(pri), .sec_in_i(sec),
        .pri_pol_i(pol), .pri_is_clk_i(pclk), .pri_is_self_i(pself),
        .casc_up_i(cu), .casc_dn_i(cd), .load_i(load), .cmp1_i(c1),
        .cmp2_i(c2), .cnt_o(cnt), .cmp_flag_o(flag)
    );

    // behavioural reference model; st: 0 run1, 1 run2, 2 wait, 3 halt
    logic [15:0] m_cnt;
    bit          m_flag;
    int          m_st;
    bit          hp[3];
    bit          hs[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'd0; m_flag = 1'b0; m_st = 0;
            foreach (hp[i]) begin hp[i] = 1'b0; hs[i] = 1'b0; end
        end else begin
            bit a, ap, b, bp, pr, pf, e, up, dn, trg;
            logic [15:0] nx, ca;
            a = hp[1]; ap = hp[2]; b = hs[1]; bp = hs[2];
            pr = a & !ap; pf = !a & ap;
            e = pclk ? 1'b1 : (pol ? pf : pr);
            up = 1'b0; dn = 1'b0;
            case (mode)
                3'd1: up = e;
                3'd2: up = !pclk && (pr || pf);
                3'd3: up = (pclk || pr) && b;
                3'd4: if ((a != ap) != (b != bp)) begin
                          if (a ^ bp) up = 1'b1; else dn = 1'b1;
                      end
                3'd5: if (b) dn = e; else up = e;
                3'd6: up = pclk || pr;
                3'd7: begin up = cu && !cd; dn = cd && !cu; end
                default: ;
            endcase
            if (pself) begin up = 1'b0; dn = 1'b0; end
            trg = b && !bp;
            m_flag = 1'b0;
            if (wr) begin
                m_cnt = load;
                m_st = (mode == 3'd6) ? 2 : 0;
            end else if (m_st == 2) begin
                if (trg) m_st = 0;
            end else if (m_st < 2 && (up || dn)) begin
                nx = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
                ca = (m_st == 1) ? c2 : c1;
                if (nx == ca) begin
                    m_flag = 1'b1;
                    if (os) begin
                        if (m_st == 0 && dual) begin m_cnt = load; m_st = 1; end
                        else begin m_cnt = nx; m_st = 3; end
                    end else begin
                        m_cnt = load;
                        m_st = (mode == 3'd6) ? 2 : 0;
                    end
                end else begin
                    m_cnt = nx;
                end
            end
            hp[2] = hp[1]; hp[1] = hp[0]; hp[0] = pri;
            hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sec;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            n_chk++;
            if (cnt !== m_cnt || flag !== m_flag) begin
                n_err++;
                $display("FAIL %s: cnt=%0d flag=%0b expected cnt=%0d flag=%0b",
                         cur_req, cnt, flag, m_cnt, m_flag);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] m, input bit o, input bit d);
        @(negedge clk);
        mode = m; os = o; dual = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tog_pri(input int n);
        for (int i = 0; i < n; i++) begin
            pri = ~pri;
            idle(3);
        end
    endtask

    task automatic set_sec(input bit v);
        sec = v;
        idle(3);
    endtask

    task automatic quad(input bit a, input bit b);
        pri = a; sec = b;
        idle(3);
    endtask

    task automatic pulse(input bit up, input bit dn);
        cu = up; cd = dn;
        @(negedge clk);
        cu = 1'b0; cd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        live = 1'b1;
        chk("R1", cnt, 16'd0);
        chk("R1", {15'd0, flag}, 16'd0);

        // R3: rising edges, then falling edges
        cur_req = "R3";
        cfg(3'd1, 0, 0);
        tog_pri(8); idle(2);
        chk("R3", cnt, 16'd4);
        pol = 1'b1;
        cfg(3'd1, 0, 0);
        tog_pri(8); idle(2);
        chk("R3", cnt, 16'd4);

        // R4: system clock as source
        cur_req = "R4";
        pclk = 1'b1;
        cfg(3'd1, 0, 0);
        idle(10);
        chk("R4", cnt, 16'd10);
        cfg(3'd2, 0, 0);
        idle(10);
        chk("R4", cnt, 16'd0);
        pclk = 1'b0; pol = 1'b0;

        // R5: both edges
        cur_req = "R5";
        cfg(3'd2, 0, 0);
        tog_pri(8); idle(2);
        chk("R5", cnt, 16'd8);

        // R6: gated
        cur_req = "R6";
        cfg(3'd3, 0, 0);
        tog_pri(4);
        set_sec(1'b1);
        tog_pri(4); idle(2);
        chk("R6", cnt, 16'd2);
        set_sec(1'b0);

        // R7: quadrature
        cur_req = "R7";
        cfg(3'd4, 0, 0);
        for (int k = 0; k < 2; k++) begin
            quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        end
        idle(2);
        chk("R7", cnt, 16'd8);
        quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
        idle(2);
        chk("R7", cnt, 16'd4);
        quad(1, 1); quad(0, 0);
        idle(2);
        chk("R7", cnt, 16'd4);

        // R8: direction from secondary
        cur_req = "R8";
        cfg(3'd5, 0, 0);
        tog_pri(6);
        set_sec(1'b1);
        tog_pri(4); idle(2);
        chk("R8", cnt, 16'd1);
        set_sec(1'b0);

        // R9: trigger then count until compare
        cur_req = "R9";
        load = 16'd0; c1 = 16'd3;
        cfg(3'd6, 0, 0);
        tog_pri(4); idle(2);
        chk("R9", cnt, 16'd0);
        set_sec(1'b1);
        tog_pri(4); idle(2);
        chk("R9", cnt, 16'd2);
        tog_pri(2);
        tog_pri(4); idle(2);
        chk("R9", cnt, 16'd0);
        set_sec(1'b0);

        // R10: cascade pulses
        cur_req = "R10";
        c1 = 16'd100;
        cfg(3'd7, 0, 0);
        repeat (5) pulse(1, 0);
        repeat (2) pulse(0, 1);
        pulse(1, 1);
        chk("R10", cnt, 16'd3);

        // R11: repeating compare with reload
        cur_req = "R11";
        pclk = 1'b1; load = 16'd5; c1 = 16'd9;
        cfg(3'd1, 0, 0);
        idle(20);
        chk("R11", cnt, 16'd5 + 16'd20 % 16'd4);

        // R12: one-shot halt and restart by mode write
        cur_req = "R12";
        load = 16'd0; c1 = 16'd4;
        cfg(3'd1, 1, 0);
        idle(12);
        chk("R12", cnt, 16'd4);
        cur_req = "R2";
        cfg(3'd1, 1, 0);
        idle(2);
        chk("R2", cnt, 16'd2);

        // R13: two-stage one-shot
        cur_req = "R13";
        load = 16'd2; c1 = 16'd5; c2 = 16'd7;
        cfg(3'd1, 1, 1);
        idle(20);
        chk("R13", cnt, 16'd7);

        // R14: self source and idle mode
        cur_req = "R14";
        load = 16'd0; c1 = 16'd100;
        pself = 1'b1;
        cfg(3'd1, 0, 0);
        idle(10);
        chk("R14", cnt, 16'd0);
        pself = 1'b0;
        load = 16'd9;
        cfg(3'd0, 0, 0);
        idle(10);
        chk("R14", cnt, 16'd9);
        pclk = 1'b0;

        live = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule